// File: doc/BRIEF.md
# ATM Cell Header Check Generator

This block sits in the transmit path of an ATM cell processor. It takes a byte-serial stream of 53-octet cells and computes a CRC-8 header check over the first four header octets. Where the settings call for it, it writes the result into the fifth octet. An optional fixed coset pattern can be XORed onto the check value before insertion. Each cell carries a flag that marks it as either a user cell or an idle cell, and each of the two kinds has its own insertion enable. When insertion is off for a cell, its fifth octet leaves exactly as it arrived.

The settings sit in an 8-bit control register that the host writes through a simple write strobe. Only three bits of that register matter here. The block copies the register when it accepts the first octet of each cell and uses that copy for the whole cell. A cell is therefore never processed with a mixture of old and new settings.

Both stream sides use valid/ready. An input octet transfers on a rising clock edge where `s_valid` and `s_ready` are both high. An output octet transfers where `m_valid` and `m_ready` are both high. A single output register sits between the two sides, so `s_ready` is high whenever that register is empty or is being emptied in the same cycle. While the downstream side stalls, the output octet and its side flags stay frozen and no new input is taken.

Top module: `atm_hec_inserter`

## Requirements
- R1: The check value is a CRC-8 with generator x^8 + x^2 + x + 1 (0x07). It is seeded with 0x00 at octet 1 of every cell and runs over octets 1 to 4, each octet taken most significant bit first. When insertion applies to the cell, the check value replaces octet 5.
- R2: When control bit 6 is 1, the inserted octet is the CRC XORed with 0x55. When bit 6 is 0, the plain CRC is inserted.
- R3: For a user cell (idle flag 0 on octet 1), control bit 5 enables insertion. When bit 5 is 0, octet 5 is forwarded as received.
- R4: For an idle cell (idle flag 1 on octet 1), control bit 1 enables insertion. When bit 1 is 0, the whole programmed header passes untouched, octet 5 included.
- R5: After reset the control register holds insertion on for both cell kinds and coset on, `m_valid` is 0 and `s_ready` is 1.
- R6: The control bits and the idle flag are sampled when octet 1 is accepted and hold for the rest of that cell. A register write in mid-cell takes effect from the next cell. `m_idle` carries the sampled flag on all 53 output octets.
- R7: Every octet other than octet 5 leaves unchanged, in order. Each accepted octet appears at the output register one cycle after acceptance. `m_soc` is 1 on octet 1 only.
- R8: `s_ready` is 0 while the output register is full and `m_ready` is 0. During such a stall, `m_data`, `m_soc` and `m_idle` hold their values.
- R9: An accepted octet with `s_soc` = 1 is treated as octet 1 wherever the octet count stood, so the block realigns after a cut-short cell.
- R10: Control bits 7, 4, 3, 2 and 0 have no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Control value: bit 6 coset, bit 5 user-cell insert, bit 1 idle-cell insert |
| s_valid | input | 1 | Input octet valid |
| s_ready | output | 1 | Block can take an input octet |
| s_data | input | 8 | Input octet |
| s_soc | input | 1 | Input octet is octet 1 of a cell |
| s_idle | input | 1 | Cell is an idle cell (sampled on octet 1) |
| m_valid | output | 1 | Output octet valid |
| m_ready | input | 1 | Downstream can take an output octet |
| m_data | output | 8 | Output octet |
| m_soc | output | 1 | Output octet is octet 1 of a cell |
| m_idle | output | 1 | Output cell is an idle cell |

## Verification
The assertions check four things on every cycle. Octets other than octet 5 pass through with one cycle of latency. Octet 5 passes through untouched whenever insertion is off for its cell. The output holds stable while stalled, and the per-cell settings stay frozen after octet 1. The check value itself can only be shown by the bench's scenarios, which compare octet 5 against an independent bit-serial model. The same goes for the choice between user and idle enables, the coset term, the mid-cell write taking effect only on the next cell, and realignment after a cut-short cell.

// File: rtl/atm_hec_pkg.sv
package atm_hec_pkg;

  localparam int unsigned OCTET_W = 8;

  // control register bit positions (host software relies on these)
  localparam int unsigned CTL_COSET_BIT    = 6;
  localparam int unsigned CTL_USER_INS_BIT = 5;
  localparam int unsigned CTL_IDLE_INS_BIT = 1;

  typedef struct packed {
    logic coset;
    logic ins_user;
    logic ins_idle;
  } hec_cfg_t;

  // one octet through the CRC, most significant bit first
  function automatic logic [OCTET_W-1:0] crc_octet_step(
    input logic [OCTET_W-1:0] crc_in,
    input logic [OCTET_W-1:0] octet,
    input logic [OCTET_W-1:0] poly
  );
    logic [OCTET_W-1:0] c;
    c = crc_in ^ octet;
    for (int b = 0; b < OCTET_W; b++) begin
      c = c[OCTET_W-1] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/hec_cfg_reg.sv
module hec_cfg_reg
  import atm_hec_pkg::*;
#(
  parameter logic [OCTET_W-1:0] RST_VALUE = 8'hF2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [OCTET_W-1:0] wdata,
  output hec_cfg_t           cfg_q
);

  localparam hec_cfg_t CFG_RST = '{
    coset:    RST_VALUE[CTL_COSET_BIT],
    ins_user: RST_VALUE[CTL_USER_INS_BIT],
    ins_idle: RST_VALUE[CTL_IDLE_INS_BIT]
  };

  hec_cfg_t wr_cfg;
  logic     unused_ctl_bits;

  assign wr_cfg.coset    = wdata[CTL_COSET_BIT];
  assign wr_cfg.ins_user = wdata[CTL_USER_INS_BIT];
  assign wr_cfg.ins_idle = wdata[CTL_IDLE_INS_BIT];
  // bits outside this block's function (scrambler and others) are dropped
  assign unused_ctl_bits = ^{wdata[7], wdata[4:2], wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= CFG_RST;
    else if (wr) cfg_q <= wr_cfg;
  end

endmodule

// File: rtl/hec_cell_tracker.sv
module hec_cell_tracker
  import atm_hec_pkg::*;
#(
  parameter int unsigned CELL_LEN = 53,
  parameter int unsigned HDR_LEN  = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  logic     soc,
  input  logic     idle_in,
  input  hec_cfg_t cfg_live,
  output logic     first,
  output logic     in_hdr,
  output logic     at_hec,
  output hec_cfg_t cell_cfg,
  output logic     cell_idle
);

  localparam int unsigned CNT_W = $clog2(CELL_LEN);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CELL_LEN - 1);
  localparam logic [CNT_W-1:0] HEC_POS  = CNT_W'(HDR_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;

  // a start marker realigns the count at once
  assign pos    = soc ? '0 : cnt_q;
  assign first  = (pos == '0);
  assign in_hdr = (pos < HEC_POS);
  assign at_hec = (pos == HEC_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cell_cfg  <= '0;
      cell_idle <= 1'b0;
    end else if (accept) begin
      cnt_q <= (pos == LAST_POS) ? '0 : pos + 1'b1;
      if (first) begin
        cell_cfg  <= cfg_live;
        cell_idle <= idle_in;
      end
    end
  end

  // R6: settings and idle flag frozen after octet 1 of a cell
  a_r6_cell_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !first) |=> ($stable(cell_cfg) && $stable(cell_idle)));

endmodule

// File: rtl/hec_crc_unit.sv
module hec_crc_unit
  import atm_hec_pkg::*;
#(
  parameter logic [OCTET_W-1:0] POLY = 8'h07
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               first,
  input  logic               in_hdr,
  input  logic [OCTET_W-1:0] data,
  output logic [OCTET_W-1:0] crc_q
);

  logic [OCTET_W-1:0] seed;
  logic [OCTET_W-1:0] crc_next;

  assign seed     = first ? '0 : crc_q;
  assign crc_next = crc_octet_step(seed, data, POLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  crc_q <= '0;
    else if (accept && in_hdr)   crc_q <= crc_next;
  end

endmodule

// File: rtl/atm_hec_inserter.sv
module atm_hec_inserter
  import atm_hec_pkg::*;
#(
  parameter int unsigned        CELL_LEN = 53,
  parameter int unsigned        HDR_LEN  = 4,
  parameter logic [OCTET_W-1:0] POLY     = 8'h07,
  parameter logic [OCTET_W-1:0] COSET    = 8'h55,
  parameter logic [OCTET_W-1:0] CTL_RST  = 8'hF2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [OCTET_W-1:0] cfg_wdata,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [OCTET_W-1:0] s_data,
  input  logic               s_soc,
  input  logic               s_idle,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [OCTET_W-1:0] m_data,
  output logic               m_soc,
  output logic               m_idle
);

  hec_cfg_t           cfg_live;
  hec_cfg_t           cell_cfg;
  logic               cell_idle;
  logic               first, in_hdr, at_hec;
  logic               accept;
  logic               insert_on;
  logic [OCTET_W-1:0] crc_q;
  logic [OCTET_W-1:0] hec_val;
  logic [OCTET_W-1:0] out_octet;
  logic               idle_d;

  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;

  hec_cfg_reg #(.RST_VALUE(CTL_RST)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .cfg_q (cfg_live)
  );

  hec_cell_tracker #(.CELL_LEN(CELL_LEN), .HDR_LEN(HDR_LEN)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .soc       (s_soc),
    .idle_in   (s_idle),
    .cfg_live  (cfg_live),
    .first     (first),
    .in_hdr    (in_hdr),
    .at_hec    (at_hec),
    .cell_cfg  (cell_cfg),
    .cell_idle (cell_idle)
  );

  hec_crc_unit #(.POLY(POLY)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .first  (first),
    .in_hdr (in_hdr),
    .data   (s_data),
    .crc_q  (crc_q)
  );

  assign insert_on = cell_idle ? cell_cfg.ins_idle : cell_cfg.ins_user;
  assign hec_val   = crc_q ^ (cell_cfg.coset ? COSET : '0);
  assign out_octet = (at_hec && insert_on) ? hec_val : s_data;
  assign idle_d    = first ? s_idle : cell_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_soc   <= 1'b0;
      m_idle  <= 1'b0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) begin
        m_data <= out_octet;
        m_soc  <= first;
        m_idle <= idle_d;
      end
    end
  end

  // R7: an accepted octet shows up at the output the next cycle
  a_r7_one_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> m_valid);

  // R7: octets other than octet 5 leave unchanged
  a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !at_hec) |=> (m_data == $past(s_data)));

  // R3 and R4: with insertion off for the cell, octet 5 leaves as received
  a_r4_octet5_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && at_hec && !insert_on) |=> (m_data == $past(s_data)));

  // R8: stalled output holds
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=>
      (m_valid && $stable(m_data) && $stable(m_soc) && $stable(m_idle)));

  // R9: start marker on input gives start marker on output
  a_r9_soc_realign: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && s_soc) |=> m_soc);

endmodule

// File: tb/test_atm_hec_inserter.sv
module test_atm_hec_inserter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = 8'h00;
  logic       s_soc = 1'b0;
  logic       s_idle = 1'b0;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic [7:0] m_data;
  logic       m_soc;
  logic       m_idle;

  always #5 clk = ~clk;

  atm_hec_inserter i_atm_hec_inserter (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_soc(s_soc), .s_idle(s_idle),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_soc(m_soc), .m_idle(m_idle)
  );

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  // vector: hdr[49:18] octet5[17:10] ctl[9:2] idle[1] backpressure[0]
  localparam int NVEC = 10;
  localparam logic [49:0] VEC [NVEC] = '{
    {32'h00000000, 8'hAA, 8'h62, 1'b0, 1'b0},
    {32'h00000001, 8'h00, 8'h62, 1'b1, 1'b0},
    {32'h00000001, 8'h3C, 8'h20, 1'b1, 1'b0},
    {32'h00000001, 8'h11, 8'h20, 1'b0, 1'b0},
    {32'h00000001, 8'h99, 8'h02, 1'b0, 1'b0},
    {32'h00000001, 8'h5A, 8'h02, 1'b1, 1'b1},
    {32'h12345678, 8'h00, 8'h60, 1'b0, 1'b1},
    {32'hFFFFFFFF, 8'h00, 8'hBF, 1'b0, 1'b1},
    {32'h0A0B0C0D, 8'h77, 8'h9D, 1'b1, 1'b0},
    {32'h00000000, 8'h00, 8'h62, 1'b1, 1'b1}
  };

  // output capture
  logic [7:0] ob [53];
  logic       os [53];
  logic       oi [53];
  int         out_cnt = 0;
  bit         bp_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  int         stall_seen = 0;
  int         stall_viol = 0;

  always @(negedge clk) begin
    lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_ready <= bp_mode ? lfsr[0] : 1'b1;
    #2;
    if (m_valid && !m_ready) begin
      stall_seen++;
      if (s_ready) stall_viol++;
    end
    if (m_valid && m_ready) begin
      if (m_soc) out_cnt = 0;
      if (out_cnt < 53) begin
        ob[out_cnt] = m_data;
        os[out_cnt] = m_soc;
        oi[out_cnt] = m_idle;
      end
      out_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bit-serial model of the header check
  function automatic logic [7:0] ref_crc(input logic [31:0] hdr);
    logic [7:0] c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic fb = c[7] ^ hdr[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  function automatic logic [7:0] ref_oct5(input logic [31:0] hdr, input logic [7:0] b5,
                                          input logic [7:0] ctl, input bit idle);
    bit ins = idle ? ctl[1] : ctl[5];
    return ins ? (ref_crc(hdr) ^ (ctl[6] ? 8'h55 : 8'h00)) : b5;
  endfunction

  function automatic logic [7:0] cell_octet(input logic [31:0] hdr, input logic [7:0] b5,
                                            input int k);
    if (k < 4) return hdr[31 - 8*k -: 8];
    if (k == 4) return b5;
    return 8'(k * 3) + hdr[7:0];
  endfunction

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk); #1;
    cfg_wr = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic send_octet(input logic [7:0] d, input bit soc, input bit idle);
    @(negedge clk); #1;
    s_valid = 1'b1; s_data = d; s_soc = soc; s_idle = idle;
    #1;
    while (!s_ready) begin
      @(negedge clk); #2;
    end
    @(posedge clk); #1;
    s_valid = 1'b0; s_soc = 1'b0;
  endtask

  // idle flag is inverted after octet 1 to show it is sampled once (R6)
  task automatic send_cell(input logic [31:0] hdr, input logic [7:0] b5, input bit idle,
                           input bit gaps, input bit mid_en, input logic [7:0] mid_ctl);
    out_cnt = 0;
    for (int k = 0; k < 53; k++) begin
      send_octet(cell_octet(hdr, b5, k), k == 0, (k == 0) ? idle : !idle);
      if (mid_en && k == 1) write_ctl(mid_ctl);
      if (gaps && (k % 5 == 4)) @(negedge clk);
    end
  endtask

  task automatic check_cell(input logic [31:0] hdr, input logic [7:0] b5, input bit idle,
                            input logic [7:0] exp5, input string req);
    bit ok_pass = 1'b1, ok_soc = 1'b1, ok_idle = 1'b1;
    while (out_cnt < 53) @(negedge clk);
    #3;
    chk(ob[4] == exp5, req, ob[4], exp5);
    for (int k = 0; k < 53; k++) begin
      if (k != 4 && ob[k] !== cell_octet(hdr, b5, k)) ok_pass = 1'b0;
      if (os[k] !== (k == 0)) ok_soc = 1'b0;
      if (oi[k] !== idle) ok_idle = 1'b0;
    end
    chk(ok_pass, "R7 other octets unchanged", ok_pass, 1);
    chk(ok_soc, "R7 start marker on octet 1 only", ok_soc, 1);
    chk(ok_idle, "R6 idle flag held for whole cell", ok_idle, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R5: reset state
    chk(m_valid == 1'b0, "R5 m_valid after reset", m_valid, 0);
    chk(s_ready == 1'b1, "R5 s_ready after reset", s_ready, 1);
    // R1: model anchor, idle header gives 0x52 with coset
    chk((ref_crc(32'h00000001) ^ 8'h55) == 8'h52, "R1 reference anchor",
        ref_crc(32'h00000001) ^ 8'h55, 8'h52);

    // R5: default settings insert with coset on an idle cell
    send_cell(32'h00000001, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    check_cell(32'h00000001, 8'h00, 1'b1, 8'h52, "R5 default insert with coset");

    // R1 R2 R3 R4 R10: vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] hdr  = VEC[v][49:18];
      logic [7:0]  b5   = VEC[v][17:10];
      logic [7:0]  ctl  = VEC[v][9:2];
      bit          idle = VEC[v][1];
      bp_mode = VEC[v][0];
      write_ctl(ctl);
      send_cell(hdr, b5, idle, bp_mode, 1'b0, 8'h00);
      check_cell(hdr, b5, idle, ref_oct5(hdr, b5, ctl, idle),
                 "R1 R2 R3 R4 R10 octet 5 value");
      bp_mode = 1'b0;
    end
    // R10: ignored bits give the same result as the clean value
    chk(ref_oct5(32'hFFFFFFFF, 8'h00, 8'hBF, 1'b0) == ref_oct5(32'hFFFFFFFF, 8'h00, 8'h22, 1'b0),
        "R10 reference consistency", 0, 0);

    // R8: stalls happened and no octet was taken during them
    chk(stall_seen > 0, "R8 stalls exercised", stall_seen, 1);
    chk(stall_viol == 0, "R8 no accept while stalled", stall_viol, 0);

    // R6: mid-cell write applies from the next cell
    write_ctl(8'h62);
    send_cell(32'h00000001, 8'h44, 1'b0, 1'b0, 1'b1, 8'h00);
    check_cell(32'h00000001, 8'h44, 1'b0, 8'h52, "R6 mid-cell write not applied");
    send_cell(32'h00000001, 8'h44, 1'b0, 1'b0, 1'b0, 8'h00);
    check_cell(32'h00000001, 8'h44, 1'b0, 8'h44, "R6 write applied next cell");

    // R9: cut-short cell followed by a fresh start marker
    write_ctl(8'h62);
    out_cnt = 0;
    for (int k = 0; k < 10; k++) send_octet(8'(k + 8'hC0), k == 0, 1'b0);
    send_cell(32'hCAFE0001, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    check_cell(32'hCAFE0001, 8'h00, 1'b0, ref_oct5(32'hCAFE0001, 8'h00, 8'h62, 1'b0),
               "R9 realign after short cell");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

endmodule